// File: doc/BRIEF.md
# Serial-Bus Activity Watchdog

This block supervises a host processor by watching the clock and data lines of a two-wire serial bus. A host that is alive keeps producing bus traffic. Each complete transaction, read or write, to any slave address, restarts a timeout counter. If the selected interval expires without a restart, the block raises a one-cycle request to the system reset generator.

A restart needs at least a START condition, one low phase and one high phase of the clock line, and then a STOP condition. Data bytes are not required. Both bus lines pass through a two-flop synchronizer into the system clock domain. A free-running prescaler divides the system clock into watchdog ticks.

A two-bit period code selects one of three tick counts or switches the watchdog off. The code is held in a local register that loads from the status-register side. While the write-protect lock input is high, that register cannot change. While the reset generator reports that reset is already active, the counter stays cleared and no request is made.

Top module: `bus_watchdog`

## Requirements
- R1: After `rstN` is released, `rstReq` is low and the period code is `DEFAULT_SEL` (00 by default). With no bus activity, the first request is high in the cycle that follows the clock edge PRESCALE×TICKS_SHORT edges after release.
- R2: The restart fires on this sequence: a START (SDA falls while SCL is high), then SCL low, then SCL high, then a STOP (SDA rises while SCL high). Because of the two-flop synchronizer and the edge register, the counter clears on the third rising clock edge after the STOP edge reaches the pins. The next request follows exactly one full interval after that clearing edge.
- R3: A STOP that follows a START with no SCL low phase and SCL high phase in between does not restart the counter.
- R4: A second START before the STOP re-arms the sequence and discards the clock phases already seen. A STOP right after that second START does not restart the counter.
- R5: Period code 00 gives PRESCALE×TICKS_SHORT cycles, code 01 gives PRESCALE×TICKS_MID cycles, and code 10 gives PRESCALE×TICKS_LONG cycles (bit 1 is `selData[1]`).
- R6: Period code 11 disables the watchdog, so `rstReq` stays low.
- R7: `selLoad` loads `selData` into the period register on a clock edge only while `wpLock` is low. While `wpLock` is high the load is ignored.
- R8: While `resetActiveIn` is high, the counter and prescaler are held at zero and `rstReq` stays low. A full interval starts from the last edge on which the input was high.
- R9: `rstReq` is a single-cycle pulse. With no restart, requests repeat once every interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line, asynchronous |
| sdaIn | input | 1 | Serial data line, asynchronous |
| selLoad | input | 1 | Load strobe for the period code |
| selData | input | 2 | New period code |
| wpLock | input | 1 | High blocks changes to the period code |
| resetActiveIn | input | 1 | High while the system reset is asserted |
| rstReq | output | 1 | One-cycle timeout request to the reset generator |

## Verification
A STOP edge driven on a falling clock edge clears the counter on the third rising edge after it. The request is therefore due PRESCALE×ticks+3 cycles after the STOP is driven. After the release of `rstN` or `resetActiveIn`, the request is due exactly PRESCALE×ticks cycles later. The bench checks each directed case at these exact cycles: low one cycle before the due cycle and high on it. A behavioural model, stepped on every rising edge, predicts `rstReq`, and the bench compares it on every falling edge. This catches early, late or extra pulses between the directed points.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  typedef enum logic [1:0] {
    SEL_SHORT = 2'b00,
    SEL_MID   = 2'b01,
    SEL_LONG  = 2'b10,
    SEL_OFF   = 2'b11
  } wdSel_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ARMED,
    SEQ_LOW,
    SEQ_READY
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   kick;
    logic   hold;
    wdSel_e sel;
  } wdCtl_t;
endpackage

// File: rtl/bwd_sync.sv
module bwd_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe[0] <= RST_VAL;
    else       pipe[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[g] <= RST_VAL;
      else       pipe[g] <= pipe[g-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/bwd_ctrl.sv
module bwd_ctrl
  import bwd_pkg::*;
#(
  parameter logic [1:0] DEFAULT_SEL = 2'b00,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       selLoad,
  input  logic [1:0] selData,
  input  logic       wpLock,
  input  logic       resetActiveIn,
  output wdCtl_t     ctl
);
  logic [1:0] busS;
  logic sclS, sdaS, sclQ, sdaQ;
  logic startDet, stopDet, kickNow;
  seqState_e seqState, seqNext;
  wdSel_e periodReg;

  bwd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rstN(rstN), .d({sclIn, sdaIn}), .q(busS)
  );

  assign sclS = busS[1];
  assign sdaS = busS[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclS;
      sdaQ <= sdaS;
    end
  end

  // data line edges while the clock line stays high
  assign startDet = sclS && sclQ && sdaQ && !sdaS;
  assign stopDet  = sclS && sclQ && !sdaQ && sdaS;

  always_comb begin
    seqNext = seqState;
    kickNow = 1'b0;
    if (startDet) begin
      seqNext = SEQ_ARMED;
    end else begin
      case (seqState)
        SEQ_ARMED: begin
          if (stopDet)    seqNext = SEQ_IDLE;
          else if (!sclS) seqNext = SEQ_LOW;
        end
        SEQ_LOW: if (sclS) seqNext = SEQ_READY;
        SEQ_READY: begin
          if (stopDet) begin
            seqNext = SEQ_IDLE;
            kickNow = 1'b1;
          end
        end
        default: seqNext = seqState;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqState  <= SEQ_IDLE;
      periodReg <= wdSel_e'(DEFAULT_SEL);
    end else begin
      seqState <= seqNext;
      if (selLoad && !wpLock) periodReg <= wdSel_e'(selData);
    end
  end

  assign ctl.kick = kickNow;
  assign ctl.hold = resetActiveIn || (periodReg == SEL_OFF);
  assign ctl.sel  = periodReg;
endmodule

// File: rtl/bwd_dp.sv
module bwd_dp
  import bwd_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int TICKS_SHORT = 8,
  parameter int TICKS_MID = 16,
  parameter int TICKS_LONG = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  wdCtl_t ctl,
  output logic   rstReq
);
  localparam int MAX_TICKS = (TICKS_LONG > TICKS_MID)
      ? ((TICKS_LONG > TICKS_SHORT) ? TICKS_LONG : TICKS_SHORT)
      : ((TICKS_MID > TICKS_SHORT) ? TICKS_MID : TICKS_SHORT);
  localparam int CNT_W = $clog2(MAX_TICKS + 1);
  localparam int PRE_W = $clog2(PRESCALE + 1);

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] tmoCnt, lastTick;
  logic tick;

  always_comb begin
    case (ctl.sel)
      SEL_SHORT: lastTick = CNT_W'(TICKS_SHORT - 1);
      SEL_MID:   lastTick = CNT_W'(TICKS_MID - 1);
      SEL_LONG:  lastTick = CNT_W'(TICKS_LONG - 1);
      default:   lastTick = '0;
    endcase
  end

  assign tick = (preCnt == PRE_W'(PRESCALE - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      tmoCnt <= '0;
      rstReq <= 1'b0;
    end else if (ctl.kick || ctl.hold) begin
      preCnt <= '0;
      tmoCnt <= '0;
      rstReq <= 1'b0;
    end else begin
      rstReq <= 1'b0;
      if (tick) begin
        preCnt <= '0;
        if (tmoCnt >= lastTick) begin
          tmoCnt <= '0;
          rstReq <= 1'b1;
        end else begin
          tmoCnt <= tmoCnt + 1'b1;
        end
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
  import bwd_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int TICKS_SHORT = 8,
  parameter int TICKS_MID = 16,
  parameter int TICKS_LONG = 32,
  parameter logic [1:0] DEFAULT_SEL = 2'b00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       selLoad,
  input  logic [1:0] selData,
  input  logic       wpLock,
  input  logic       resetActiveIn,
  output logic       rstReq
);
  wdCtl_t ctl;

  bwd_ctrl #(.DEFAULT_SEL(DEFAULT_SEL), .SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .selLoad(selLoad), .selData(selData), .wpLock(wpLock),
    .resetActiveIn(resetActiveIn), .ctl(ctl)
  );

  bwd_dp #(
    .PRESCALE(PRESCALE), .TICKS_SHORT(TICKS_SHORT),
    .TICKS_MID(TICKS_MID), .TICKS_LONG(TICKS_LONG)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rstReq(rstReq)
  );
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rstReq,
  input logic       resetActiveIn,
  input logic       wpLock,
  input logic       kick,
  input logic [1:0] curSel
);
  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetActiveIn |=> !rstReq);

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curSel == 2'b11) |=> !rstReq);

  // R7
  locked_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    wpLock |=> $stable(curSel));

  // R2
  kick_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    kick |=> !rstReq);
endmodule

bind bus_watchdog bwd_checker u_chk (
  .clk(clk), .rstN(rstN), .rstReq(rstReq), .resetActiveIn(resetActiveIn),
  .wpLock(wpLock), .kick(ctl.kick), .curSel(ctl.sel)
);

// File: tb/bus_watchdog_bench.sv
`timescale 1ns/1ps
module bus_watchdog_bench;
  localparam int PRE = 4;
  localparam int TS = 8, TM = 16, TL = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1, sdaIn = 1'b1;
  logic selLoad = 1'b0, wpLock = 1'b0, resetActiveIn = 1'b0;
  logic [1:0] selData = 2'b00;
  logic rstReq;

  int checks = 0, fails = 0, cyc = 0, pulseCount = 0;
  bit modelOn = 0;

  bus_watchdog #(.PRESCALE(PRE), .TICKS_SHORT(TS), .TICKS_MID(TM),
                 .TICKS_LONG(TL), .DEFAULT_SEL(2'b00)) u_bus_watchdog (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .selLoad(selLoad), .selData(selData), .wpLock(wpLock),
    .resetActiveIn(resetActiveIn), .rstReq(rstReq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural reference: pin history queues, integer counters
  bit sclHist[$], sdaHist[$];
  int mSeq = 0, mPre = 0, mCnt = 0, mSel = 0;
  bit mExp = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      sclHist = '{1, 1, 1}; sdaHist = '{1, 1, 1};
      mSeq = 0; mPre = 0; mCnt = 0; mSel = 0; mExp = 0;
    end else begin
      bit st, sp, kk, hd, tk;
      int lim;
      // index 1 is the synchronized sample, index 2 the previous one
      st = sclHist[1] && sclHist[2] && sdaHist[2] && !sdaHist[1];
      sp = sclHist[1] && sclHist[2] && !sdaHist[2] && sdaHist[1];
      kk = (mSeq == 3) && sp;
      if (st) mSeq = 1;
      else if (mSeq == 1) mSeq = sp ? 0 : (!sclHist[1] ? 2 : 1);
      else if (mSeq == 2) mSeq = sclHist[1] ? 3 : 2;
      else if (mSeq == 3 && sp) mSeq = 0;
      hd = resetActiveIn || (mSel == 3);
      lim = (mSel == 0) ? TS : (mSel == 1) ? TM : TL;
      mExp = 0;
      if (kk || hd) begin
        mPre = 0; mCnt = 0;
      end else begin
        tk = (mPre == PRE - 1);
        mPre = tk ? 0 : mPre + 1;
        if (tk) begin
          if (mCnt >= lim - 1) begin mCnt = 0; mExp = 1; end
          else mCnt++;
        end
      end
      if (selLoad && !wpLock) mSel = selData;
      void'(sclHist.pop_back()); void'(sdaHist.pop_back());
      sclHist.push_front(sclIn); sdaHist.push_front(sdaIn);
    end
  end

  always @(negedge clk) begin
    if (rstN && rstReq) pulseCount++;
    if (modelOn) begin
      checks++;
      if (rstReq !== mExp) begin
        fails++;
        $display("FAIL R9 per-cycle model at cyc %0d: got %b expected %b", cyc, rstReq, mExp);
      end
    end
  end

  task automatic check(input bit cond, input string tag, input int got, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (cyc %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic setBus(input bit s, input bit d, output int when);
    @(negedge clk);
    sclIn = s; sdaIn = d; when = cyc;
    repeat (2) @(negedge clk);
  endtask

  task automatic checkPulseAt(input int e, input string tag);
    while (cyc < e - 1) @(negedge clk);
    check(rstReq === 1'b0, {tag, " low before due"}, rstReq, 0);
    @(negedge clk);
    check(rstReq === 1'b1, {tag, " pulse due"}, rstReq, 1);
  endtask

  task automatic holdLoad(input bit lock, input logic [1:0] code, output int rel);
    @(negedge clk); resetActiveIn = 1'b1;
    repeat (3) @(negedge clk);
    wpLock = lock; selLoad = 1'b1; selData = code;
    @(negedge clk); selLoad = 1'b0; wpLock = 1'b0;
    repeat (3) @(negedge clk);
    resetActiveIn = 1'b0; rel = cyc;
  endtask

  initial begin
    int c0, cs, t, pc;
    repeat (3) @(negedge clk);
    rstN = 1'b1; c0 = cyc; modelOn = 1;
    // R1: idle output after reset, default code 00
    check(rstReq === 1'b0, "R1 reset state", rstReq, 0);
    checkPulseAt(c0 + PRE*TS, "R1 first timeout with default code");
    // R9: repeats each interval
    checkPulseAt(c0 + 2*PRE*TS, "R9 periodic request");

    // R2: minimum restart sequence
    setBus(1, 0, t); setBus(0, 0, t); setBus(1, 0, t); setBus(1, 1, cs);
    checkPulseAt(cs + 3 + PRE*TS, "R2 restart after stop");
    pc = cyc;

    // R3: start immediately followed by stop
    setBus(1, 0, t); setBus(1, 1, t);
    checkPulseAt(pc + PRE*TS, "R3 stop without clock ignored");
    pc = cyc;

    // R4: second start re-arms, then bare stop
    setBus(1, 0, t); setBus(0, 0, t); setBus(0, 1, t); setBus(1, 1, t);
    setBus(1, 0, t); setBus(1, 1, t);
    checkPulseAt(pc + PRE*TS, "R4 re-armed stop ignored");

    // R8 + R7: hold long, locked load of code 10 during hold
    @(negedge clk); resetActiveIn = 1'b1; pc = pulseCount;
    repeat (20) @(negedge clk);
    wpLock = 1'b1; selLoad = 1'b1; selData = 2'b10;
    @(negedge clk); selLoad = 1'b0; wpLock = 1'b0;
    repeat (60) @(negedge clk);
    check(pulseCount == pc, "R8 no request while reset active", pulseCount - pc, 0);
    resetActiveIn = 1'b0; t = cyc;
    checkPulseAt(t + PRE*TS, "R7 locked load ignored, R8 full interval");

    // R5: code 01 and 10
    holdLoad(0, 2'b01, t);
    checkPulseAt(t + PRE*TM, "R5 code 01 interval");
    holdLoad(0, 2'b10, t);
    checkPulseAt(t + PRE*TL, "R5 code 10 interval");
    checkPulseAt(t + 2*PRE*TL, "R9 repeat at code 10");

    // R6: code 11 disables
    holdLoad(0, 2'b11, t); pc = pulseCount;
    repeat (3*PRE*TL) @(negedge clk);
    check(pulseCount == pc, "R6 disabled watchdog quiet", pulseCount - pc, 0);

    // R7: unlocked return to 00 works again
    holdLoad(0, 2'b00, t);
    checkPulseAt(t + PRE*TS, "R7 unlocked load accepted");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule